// File: doc/BRIEF.md
# Eviction Shadow-Copy Undo Logger

This block sits in the replacement path of a two-version L1 data cache during transactional execution. Each line that leaves the cache is offered to it with its physical line address, the older (shadow) copy of its data, a transactionally-modified flag and a flag saying the shadow copy is valid. The block keeps one such line in a holding register. It then either writes the line to an undo log in memory or discards it.

A line is logged only when the transaction's write set no longer fits in the cache. That means a modified line whose shadow copy is valid has been evicted. Lines whose address falls inside the log region are never logged, so that writing the log can never cause further logging. Each logged entry advances a write pointer through the log region and sets a sticky overflow flag. Abort handling reads that flag to decide whether a software unroll must follow the in-cache restore. A commit, or the end of an abort, rewinds the log and clears the flags.

Top module: `shadow_log_buf`

## Requirements
- R1: After reset, `evict_ready` is 1 and `log_valid`, `log_overflow` and `log_error` are 0.
- R2: An accepted eviction with `evict_mod`=1, `evict_vsc`=1, an address outside [`log_base`, `log_limit`) and room in the log raises `log_valid` in the cycle after acceptance. `log_addr` equals the current write pointer, which starts at `log_base`. The low 64 bits of `log_data` hold the zero-extended line address and the bits above hold the line data.
- R3: An accepted eviction with `evict_mod`=0 or `evict_vsc`=0 is dropped. No log write follows, and the write pointer does not move.
- R4: An accepted eviction whose address lies in [`log_base`, `log_limit`) is dropped, even when both flags are set. The write pointer does not move.
- R5: While `log_valid` is 1, `evict_ready` is 0. `log_valid`, `log_addr` and `log_data` hold their values until a cycle with `log_ready`=1.
- R6: Each completed log handshake advances the write pointer by STRIDE = LINE_W/8 + 8 bytes and sets `log_overflow`.
- R7: If the write pointer plus STRIDE would exceed `log_limit` when a loggable eviction is accepted, the line is dropped, `log_error` is set, and the pointer stays where it is.
- R8: A `txn_commit` pulse rewinds the pointer to `log_base`, clears `log_overflow` and `log_error`, and discards any pending entry.
- R9: An `abort_done` pulse has the same effect as `txn_commit`.
- R10: `log_overflow` and `log_error` are sticky. They stay set across further evictions until a commit or the end of an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | An evicted line is offered |
| evict_ready | output | 1 | Holding register is free |
| evict_addr | input | ADDR_W | Physical line address of the evicted line |
| evict_data | input | LINE_W | Shadow-copy data of the line |
| evict_mod | input | 1 | Line was transactionally modified |
| evict_vsc | input | 1 | Shadow copy is valid |
| log_base | input | ADDR_W | First byte address of the log region |
| log_limit | input | ADDR_W | First byte address past the log region |
| txn_commit | input | 1 | Transaction committed (one-cycle pulse) |
| abort_done | input | 1 | Abort handling finished (one-cycle pulse) |
| log_valid | output | 1 | A log write is pending |
| log_ready | input | 1 | Memory side accepts the log write |
| log_addr | output | ADDR_W | Byte address of the log entry |
| log_data | output | LINE_W+64 | Entry payload: line data above a 64-bit address slot |
| log_overflow | output | 1 | At least one entry has been logged |
| log_error | output | 1 | A loggable line was dropped because the log was full |

## Verification
The bench builds the block with ADDR_W=16 and LINE_W=64. This gives a 16-byte entry stride, and with a 64-byte log region it allows exactly four entries. With that region, filling the log, hitting the limit and seeing the error on the fifth entry take only a few dozen cycles. The narrow line also makes every payload bit easy to predict and compare. The small address space places evictions below, inside and at the edges of the log region, and exercises rewinds with an entry still pending.

// File: rtl/slb_pkg.sv
package slb_pkg;
  // Width of the address slot that precedes the line data in every entry.
  localparam int unsigned ADDR_SLOT_BITS = 64;
  localparam int unsigned ADDR_SLOT_BYTES = ADDR_SLOT_BITS / 8;

  // Bytes occupied by one log entry for a given line width.
  function automatic int unsigned entry_stride(input int unsigned line_w);
    return line_w / 8 + ADDR_SLOT_BYTES;
  endfunction
endpackage

// File: rtl/slb_filter.sv
module slb_filter #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned STRIDE = 72
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mod,
  input  logic              vsc,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] wr_ptr,
  output logic              want_log,
  output logic              no_room
);
  localparam logic [ADDR_W:0] STRIDE_W = (ADDR_W+1)'(STRIDE);

  logic              in_region;
  logic              cond;
  logic [ADDR_W:0]   entry_end;

  always_comb begin
    in_region = (addr >= base) && (addr < limit);
    cond      = mod && vsc && !in_region;
    entry_end = {1'b0, wr_ptr} + STRIDE_W;
    no_room   = cond && (entry_end > {1'b0, limit});
    want_log  = cond && !no_room;
  end
endmodule

// File: rtl/slb_ptr.sv
module slb_ptr #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned STRIDE = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  input  logic              err_set,
  output logic [ADDR_W-1:0] offset,
  output logic              ovf,
  output logic              err
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] offset_d;
  logic              ovf_d;
  logic              err_d;
  logic              en;

  always_comb begin
    en       = clear || adv || err_set;
    offset_d = offset;
    ovf_d    = ovf;
    err_d    = err;
    if (clear) begin
      offset_d = '0;
      ovf_d    = 1'b0;
      err_d    = 1'b0;
    end else begin
      if (adv) begin
        offset_d = offset + STEP;
        ovf_d    = 1'b1;
      end
      if (err_set) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      ovf    <= 1'b0;
      err    <= 1'b0;
    end else if (en) begin
      offset <= offset_d;
      ovf    <= ovf_d;
      err    <= err_d;
    end
  end
endmodule

// File: rtl/slb_hold.sv
module slb_hold #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  logic              clear,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LINE_W-1:0] in_data,
  output logic              pend,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LINE_W-1:0] data_q
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (clear)     pend_d = 1'b0;
    else if (load) pend_d = 1'b1;
    else if (take) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  // Payload registers carry no reset; they are only read while pend is set.
  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= in_addr;
      data_q <= in_data;
    end
  end
endmodule

// File: rtl/shadow_log_buf.sv
module shadow_log_buf #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LINE_W = 512
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   evict_valid,
  output logic                                   evict_ready,
  input  logic [ADDR_W-1:0]                      evict_addr,
  input  logic [LINE_W-1:0]                      evict_data,
  input  logic                                   evict_mod,
  input  logic                                   evict_vsc,
  input  logic [ADDR_W-1:0]                      log_base,
  input  logic [ADDR_W-1:0]                      log_limit,
  input  logic                                   txn_commit,
  input  logic                                   abort_done,
  output logic                                   log_valid,
  input  logic                                   log_ready,
  output logic [ADDR_W-1:0]                      log_addr,
  output logic [LINE_W+slb_pkg::ADDR_SLOT_BITS-1:0] log_data,
  output logic                                   log_overflow,
  output logic                                   log_error
);
  import slb_pkg::*;

  localparam int unsigned STRIDE = entry_stride(LINE_W);

  logic              accept, want_log, no_room;
  logic              clear, load, take, adv, err_set;
  logic              pend;
  logic [ADDR_W-1:0] offset, wr_ptr, addr_q;
  logic [LINE_W-1:0] data_q;
  logic [ADDR_SLOT_BITS-1:0] addr_slot;

  always_comb begin
    wr_ptr  = log_base + offset;
    accept  = evict_valid && !pend;
    clear   = txn_commit || abort_done;
    take    = pend && log_ready;
    load    = accept && want_log && !clear;
    adv     = take && !clear;
    err_set = accept && no_room && !clear;
  end

  slb_filter #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_filter (
    .addr(evict_addr), .mod(evict_mod), .vsc(evict_vsc),
    .base(log_base), .limit(log_limit), .wr_ptr(wr_ptr),
    .want_log(want_log), .no_room(no_room)
  );

  slb_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .adv(adv), .err_set(err_set),
    .offset(offset), .ovf(log_overflow), .err(log_error)
  );

  slb_hold #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .take(take), .clear(clear),
    .in_addr(evict_addr), .in_data(evict_data),
    .pend(pend), .addr_q(addr_q), .data_q(data_q)
  );

  always_comb begin
    addr_slot               = '0;
    addr_slot[ADDR_W-1:0]   = addr_q;
    evict_ready             = !pend;
    log_valid               = pend;
    log_addr                = wr_ptr;
    log_data                = {data_q, addr_slot};
  end
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LINE_W = 512
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     evict_valid,
  input logic                     evict_ready,
  input logic                     evict_mod,
  input logic                     evict_vsc,
  input logic [ADDR_W-1:0]        log_limit,
  input logic                     txn_commit,
  input logic                     abort_done,
  input logic                     log_valid,
  input logic                     log_ready,
  input logic [ADDR_W-1:0]        log_addr,
  input logic [LINE_W+63:0]       log_data,
  input logic                     log_overflow,
  input logic                     log_error
);
  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(LINE_W/8 + 8);

  // R5
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready && !txn_commit && !abort_done) |=>
      (log_valid && $stable(log_addr) && $stable(log_data)));

  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> !evict_ready);

  // R3
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && evict_ready && !(evict_mod && evict_vsc)) |=> !log_valid);

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_overflow) |-> $past(log_valid && log_ready));

  // R7
  entry_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> (({1'b0, log_addr} + STEP) <= {1'b0, log_limit}));

  // R8
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_commit |=> (!log_valid && !log_overflow && !log_error));

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> (!log_valid && !log_overflow && !log_error));

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_error && !txn_commit && !abort_done) |=> log_error);
endmodule

bind shadow_log_buf slb_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evict_valid(evict_valid), .evict_ready(evict_ready),
  .evict_mod(evict_mod), .evict_vsc(evict_vsc), .log_limit(log_limit),
  .txn_commit(txn_commit), .abort_done(abort_done), .log_valid(log_valid),
  .log_ready(log_ready), .log_addr(log_addr), .log_data(log_data),
  .log_overflow(log_overflow), .log_error(log_error)
);

// File: tb/shadow_log_buf_test.sv
module shadow_log_buf_test;
  localparam int unsigned AW = 16;
  localparam int unsigned LW = 64;
  localparam logic [AW-1:0] BASE  = 16'h1000;
  localparam logic [AW-1:0] LIMIT = 16'h1040;

  logic clk, rst_n;
  logic evict_valid, evict_ready, evict_mod, evict_vsc;
  logic [AW-1:0] evict_addr;
  logic [LW-1:0] evict_data;
  logic txn_commit, abort_done, log_valid, log_ready;
  logic [AW-1:0] log_addr;
  logic [LW+63:0] log_data;
  logic log_overflow, log_error;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  shadow_log_buf #(.ADDR_W(AW), .LINE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_addr(evict_addr), .evict_data(evict_data), .evict_mod(evict_mod),
    .evict_vsc(evict_vsc), .log_base(BASE), .log_limit(LIMIT),
    .txn_commit(txn_commit), .abort_done(abort_done), .log_valid(log_valid),
    .log_ready(log_ready), .log_addr(log_addr), .log_data(log_data),
    .log_overflow(log_overflow), .log_error(log_error)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offer one line; returns at the negedge after the accepting edge.
  task automatic evict(input logic [AW-1:0] a, input logic [LW-1:0] d,
                       input logic m, input logic v);
    @(negedge clk);
    evict_addr = a; evict_data = d; evict_mod = m; evict_vsc = v;
    evict_valid = 1;
    @(negedge clk);
    evict_valid = 0;
  endtask

  task automatic drain;
    log_ready = 1;
    @(negedge clk);
    log_ready = 0;
  endtask

  task automatic pulse_commit;
    txn_commit = 1; @(negedge clk); txn_commit = 0;
  endtask

  task automatic pulse_abort;
    abort_done = 1; @(negedge clk); abort_done = 0;
  endtask

  function automatic logic [127:0] entry(input logic [AW-1:0] a, input logic [LW-1:0] d);
    return {d, 48'h0, a};
  endfunction

  task automatic t_reset;
    chk("R1 evict_ready", evict_ready, 1);
    chk("R1 log_valid", log_valid, 0);
    chk("R1 log_overflow", log_overflow, 0);
    chk("R1 log_error", log_error, 0);
  endtask

  task automatic t_basic;
    evict(16'h0200, 64'hDEAD_BEEF_0123_4567, 1, 1);
    chk("R2 log_valid", log_valid, 1);
    chk("R2 log_addr", log_addr, BASE);
    chk("R2 log_data", log_data, entry(16'h0200, 64'hDEAD_BEEF_0123_4567));
    chk("R5 evict_ready low", evict_ready, 0);
    // Offer another line while busy: must not be taken.
    evict(16'h0300, 64'h1111, 1, 1);
    @(negedge clk);
    chk("R5 held valid", log_valid, 1);
    chk("R5 held data", log_data, entry(16'h0200, 64'hDEAD_BEEF_0123_4567));
    chk("R10 ovf not yet", log_overflow, 0);
    drain;
    chk("R6 valid drops", log_valid, 0);
    chk("R6 overflow set", log_overflow, 1);
    chk("R5 ready back", evict_ready, 1);
  endtask

  task automatic t_drops;
    evict(16'h0400, 64'h2222, 1, 0);
    chk("R3 no log vsc=0", log_valid, 0);
    evict(16'h0440, 64'h3333, 0, 1);
    chk("R3 no log mod=0", log_valid, 0);
    evict(16'h1020, 64'h4444, 1, 1);
    chk("R4 no log in region", log_valid, 0);
    evict(16'h1000, 64'h4545, 1, 1);
    chk("R4 no log at base", log_valid, 0);
    evict(16'h1040, 64'h5555, 1, 1);
    chk("R4 limit is outside", log_valid, 1);
    chk("R3 R4 R6 pointer", log_addr, 16'h1010);
    chk("R2 payload 2", log_data, entry(16'h1040, 64'h5555));
    drain;
    chk("R10 overflow stays", log_overflow, 1);
  endtask

  task automatic t_full;
    evict(16'h0500, 64'h6666, 1, 1);
    chk("R6 third entry", log_addr, 16'h1020);
    drain;
    evict(16'h0540, 64'h7777, 1, 1);
    chk("R6 fourth entry", log_addr, 16'h1030);
    drain;
    evict(16'h0580, 64'h8888, 1, 1);
    chk("R7 no write", log_valid, 0);
    chk("R7 error", log_error, 1);
    evict(16'h05C0, 64'h9999, 0, 0);
    chk("R10 error sticky", log_error, 1);
    chk("R7 still no write", log_valid, 0);
  endtask

  task automatic t_commit;
    pulse_commit;
    chk("R8 overflow clear", log_overflow, 0);
    chk("R8 error clear", log_error, 0);
    evict(16'h0600, 64'hAAAA, 1, 1);
    chk("R8 pointer rewound", log_addr, BASE);
    // Commit with the entry still pending discards it.
    pulse_commit;
    chk("R8 pending dropped", log_valid, 0);
    chk("R8 ready", evict_ready, 1);
    chk("R8 ovf clear", log_overflow, 0);
  endtask

  task automatic t_abort;
    evict(16'h0700, 64'hBBBB, 1, 1);
    drain;
    chk("R6 ovf before abort", log_overflow, 1);
    evict(16'h0740, 64'hCCCC, 1, 1);
    chk("R6 second after commit", log_addr, 16'h1010);
    pulse_abort;
    chk("R9 pending dropped", log_valid, 0);
    chk("R9 ovf clear", log_overflow, 0);
    evict(16'h0780, 64'hDDDD, 1, 1);
    chk("R9 pointer rewound", log_addr, BASE);
    chk("R9 payload", log_data, entry(16'h0780, 64'hDDDD));
    drain;
  endtask

  initial begin
    rst_n = 0; evict_valid = 0; evict_addr = '0; evict_data = '0;
    evict_mod = 0; evict_vsc = 0; txn_commit = 0; abort_done = 0; log_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_drops;
    t_full;
    t_commit;
    t_abort;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule